// File: doc/BRIEF.md
# Clock and Frame-Pulse Health Monitor

This block watches the timing signals that two redundant cross-connect sources deliver to a line card. Each source sends a fast system clock of roughly 38 MHz and a 2 kHz frame-header pulse. The monitor runs from a local free-running reference clock. For each source it gives one line-state bit that reports whether that source's clock and frame pulse can be trusted.

Checks run at a slow fixed polling interval, which is 50 ms in hardware and a short parameter value in simulation. At the start of each interval a gate of reference-clock cycles counts edges of the monitored clock. The count crosses into the reference domain through a toggle flop and a synchronizer. Across the whole interval, the spacing of every frame pulse is measured in reference cycles. At the end of each interval both verdicts are combined. One failed check marks the source abnormal at once. Several consecutive good checks are needed before it is marked normal again.

A status word collects, for each source, the presence and fault indications supplied from outside, the line-state bit, and a derived "source bad" bit. It also carries a current-working-source bit that passes through unchanged.

Top module: `clkfp_health_mon`

## Requirements
- R1: `line_state[s]` is 1 for abnormal and 0 for normal, with bit 0 for source A (main) and bit 1 for source B (spare). It changes only on the reference edge that ends a polling interval, which is every `POLL_CYCLES` reference cycles counted from reset release.
- R2: The clock check counts monitored-clock edges during the first `GATE_CYCLES` reference cycles of each interval. It passes only if the count lies within `CLK_NOM_EDGES` ± `CLK_TOL`, inclusive.
- R3: A single failed check, on either the clock or the frame pulse, sets that source's line state to 1 at the end of that interval and clears its good-check count.
- R4: A line state at 1 returns to 0 only at the end of the `GOOD_NEEDED`-th consecutive passing interval (5 by default). Any failing interval restarts the count from zero.
- R5: The frame check passes only if every gap between consecutive frame pulses is within `FP_PERIOD` ± `FP_TOL` reference cycles, inclusive. A missing pulse fails the check, and so does an extra pulse.
- R6: The sources are checked independently. A fault on one source never changes the other source's line state.
- R7: After reset, both line-state bits are 1 and both good-check counts are zero.
- R8: `status` is registered, so it shows one cycle later the inputs and line state of the cycle before. For source s it holds bit 4s = absent, bit 4s+1 = fault, bit 4s+2 = line state, and bit 4s+3 = bad, where bad = absent OR fault OR line state. `status` is zero during reset.
- R9: The top bit of `status`, bit 4·N_SRC, repeats `src_working` one cycle later with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | N_SRC (2) | Monitored system clock of each source |
| frame_pulse | input | N_SRC (2) | Frame-header pulse of each source, at least one reference cycle wide |
| src_absent | input | N_SRC (2) | 1 when a source is not present |
| src_fault | input | N_SRC (2) | 1 when a source reports a fault |
| src_working | input | 1 | Index of the source currently in use |
| line_state | output | N_SRC (2) | Per-source line state: 1 abnormal, 0 normal |
| status | output | 4·N_SRC+1 (9) | Registered status word (layout in R8, R9) |

## Verification
The assertions assume a reference clock more than twice as fast as each monitored clock, so that every toggle of the crossing flop is seen. They also assume frame pulses that stay high for at least one reference cycle, and a gate shorter than the polling interval. The stimulus runs a 50 MHz monitored clock against the 200 MHz reference. It slows that clock only to 40 MHz and drives each frame pulse high for exactly one reference cycle, placed on the falling edge. Faults are injected in the middle of an interval, so each one lands in a known check window.

// File: rtl/clkfp_health_pkg.sv
package clkfp_health_pkg;
    // bit positions inside one source's status nibble
    localparam int ST_ABSENT  = 0;
    localparam int ST_FAULT   = 1;
    localparam int ST_LINE    = 2;
    localparam int ST_BAD     = 3;
    localparam int ST_PER_SRC = 4;

    // per-source hysteresis decision
    typedef enum logic [1:0] {
        HY_HOLD  = 2'd0,
        HY_FAIL  = 2'd1,
        HY_COUNT = 2'd2,
        HY_CLEAR = 2'd3
    } hyst_act_e;
endpackage

// File: rtl/clkfp_rate_chk.sv
module clkfp_rate_chk #(
    parameter int GATE_CYCLES   = 100000,
    parameter int CLK_NOM_EDGES = 38880,
    parameter int CLK_TOL       = 39
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic gate_open,
    input  logic gate_end,
    output logic rate_ok
);
    localparam int CNT_W = $clog2(GATE_CYCLES + 2);
    localparam int LO    = CLK_NOM_EDGES - CLK_TOL;
    localparam int HI    = CLK_NOM_EDGES + CLK_TOL;

    // toggle flop in the monitored domain: one flip per monitored edge
    logic tog_q;
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } rate_st_t;

    rate_st_t st_d, st_q;
    logic       seen_edge;
    logic [CNT_W-1:0] total;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], tog_q};
        seen_edge = st_q.sync[2] ^ st_q.sync[1];
        total     = st_q.cnt + CNT_W'(seen_edge);
        if (gate_end) begin
            st_d.ok  = (int'(total) >= LO) && (int'(total) <= HI);
            st_d.cnt = '0;
        end else if (gate_open) begin
            st_d.cnt = total;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate_ok = st_q.ok;
endmodule

// File: rtl/clkfp_frame_chk.sv
module clkfp_frame_chk #(
    parameter int FP_PERIOD = 50000,
    parameter int FP_TOL    = 1
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic frame_pulse,
    input  logic poll_tick,
    output logic frame_ok
);
    localparam int GAP_MAX = FP_PERIOD + FP_TOL;
    localparam int GAP_MIN = FP_PERIOD - FP_TOL;
    localparam int GAP_W   = $clog2(GAP_MAX + 2);

    typedef struct packed {
        logic [2:0]       sync;
        logic [GAP_W-1:0] gap;
        logic             armed;
        logic             bad;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic    hit;
    logic    bad_now;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], frame_pulse};
        hit       = st_q.sync[1] & ~st_q.sync[2];
        bad_now   = 1'b0;
        if (hit) begin
            if (st_q.armed &&
                ((int'(st_q.gap) < GAP_MIN) || (int'(st_q.gap) > GAP_MAX)))
                bad_now = 1'b1;
            st_d.gap   = GAP_W'(1);
            st_d.armed = 1'b1;
        end else begin
            if (int'(st_q.gap) <= GAP_MAX) st_d.gap = st_q.gap + 1'b1;
            if (int'(st_q.gap) > GAP_MAX)  bad_now  = 1'b1;
        end
        st_d.bad = poll_tick ? 1'b0 : (st_q.bad | bad_now);
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_ok = ~(st_q.bad | bad_now);
endmodule

// File: rtl/clkfp_line_hyst.sv
module clkfp_line_hyst
    import clkfp_health_pkg::*;
#(
    parameter int GOOD_NEEDED = 5
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic poll_tick,
    input  logic chk_pass,
    output logic line_bad
);
    localparam int GCW = $clog2(GOOD_NEEDED + 1);

    typedef struct packed {
        logic           line;
        logic [GCW-1:0] good;
    } hy_st_t;

    hy_st_t    st_d, st_q;
    hyst_act_e act;

    always_comb begin
        act = HY_HOLD;
        if (poll_tick) begin
            if (!chk_pass)                               act = HY_FAIL;
            else if (st_q.line &&
                     int'(st_q.good) == GOOD_NEEDED - 1) act = HY_CLEAR;
            else if (st_q.line)                          act = HY_COUNT;
        end
        st_d = st_q;
        unique case (act)
            HY_FAIL:  begin st_d.line = 1'b1; st_d.good = '0; end
            HY_CLEAR: begin st_d.line = 1'b0; st_d.good = '0; end
            HY_COUNT: st_d.good = st_q.good + 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= 1'b1;
            st_q.good <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_bad = st_q.line;
endmodule

// File: rtl/clkfp_health_mon.sv
module clkfp_health_mon
    import clkfp_health_pkg::*;
#(
    parameter int N_SRC         = 2,
    parameter int POLL_CYCLES   = 5000000,
    parameter int GATE_CYCLES   = 100000,
    parameter int CLK_NOM_EDGES = 38880,
    parameter int CLK_TOL       = 39,
    parameter int FP_PERIOD     = 50000,
    parameter int FP_TOL        = 1,
    parameter int GOOD_NEEDED   = 5
) (
    input  logic                          clk_ref,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              mon_clk,
    input  logic [N_SRC-1:0]              frame_pulse,
    input  logic [N_SRC-1:0]              src_absent,
    input  logic [N_SRC-1:0]              src_fault,
    input  logic                          src_working,
    output logic [N_SRC-1:0]              line_state,
    output logic [ST_PER_SRC*N_SRC:0]     status
);
    localparam int PW     = $clog2(POLL_CYCLES);
    localparam int STAT_W = ST_PER_SRC * N_SRC + 1;

    typedef struct packed {
        logic [PW-1:0]     poll;
        logic [STAT_W-1:0] stat;
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       poll_tick;
    logic       gate_open;
    logic       gate_end;
    logic [N_SRC-1:0] rate_ok;
    logic [N_SRC-1:0] frame_ok;
    logic [N_SRC-1:0] chk_pass;

    assign poll_tick = (st_q.poll == PW'(POLL_CYCLES - 1));
    assign gate_open = (int'(st_q.poll) < GATE_CYCLES);
    assign gate_end  = (st_q.poll == PW'(GATE_CYCLES - 1));

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        clkfp_rate_chk #(
            .GATE_CYCLES  (GATE_CYCLES),
            .CLK_NOM_EDGES(CLK_NOM_EDGES),
            .CLK_TOL      (CLK_TOL)
        ) u_rate (
            .clk_ref  (clk_ref),
            .rst_n    (rst_n),
            .mon_clk  (mon_clk[s]),
            .gate_open(gate_open),
            .gate_end (gate_end),
            .rate_ok  (rate_ok[s])
        );

        clkfp_frame_chk #(
            .FP_PERIOD(FP_PERIOD),
            .FP_TOL   (FP_TOL)
        ) u_frame (
            .clk_ref    (clk_ref),
            .rst_n      (rst_n),
            .frame_pulse(frame_pulse[s]),
            .poll_tick  (poll_tick),
            .frame_ok   (frame_ok[s])
        );

        assign chk_pass[s] = rate_ok[s] & frame_ok[s];

        clkfp_line_hyst #(
            .GOOD_NEEDED(GOOD_NEEDED)
        ) u_hyst (
            .clk_ref  (clk_ref),
            .rst_n    (rst_n),
            .poll_tick(poll_tick),
            .chk_pass (chk_pass[s]),
            .line_bad (line_state[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.poll = poll_tick ? '0 : st_q.poll + 1'b1;
        for (int s = 0; s < N_SRC; s++) begin
            st_d.stat[ST_PER_SRC*s + ST_ABSENT] = src_absent[s];
            st_d.stat[ST_PER_SRC*s + ST_FAULT]  = src_fault[s];
            st_d.stat[ST_PER_SRC*s + ST_LINE]   = line_state[s];
            st_d.stat[ST_PER_SRC*s + ST_BAD]    =
                src_absent[s] | src_fault[s] | line_state[s];
        end
        st_d.stat[STAT_W-1] = src_working;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;
endmodule

// File: rtl/clkfp_health_mon_sva.sv
module clkfp_health_mon_sva #(
    parameter int N_SRC = 2
) (
    input logic                 clk_ref,
    input logic                 rst_n,
    input logic                 poll_tick,
    input logic [N_SRC-1:0]     chk_pass,
    input logic [N_SRC-1:0]     line_state,
    input logic [4*N_SRC:0]     status,
    input logic                 src_working
);
    // R1: line state moves only on the interval-ending edge
    a_r1_hold_between_ticks: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !poll_tick |=> $stable(line_state));

    // R3: a failed check forces abnormal on the next state
    a_r3_fail_sets_abnormal: assert property (@(posedge clk_ref) disable iff (!rst_n)
        poll_tick |=> ((line_state & $past(~chk_pass)) == $past(~chk_pass)));

    // R4: a drop to normal follows a tick with a passing check on that source
    a_r4_clear_needs_pass: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (|($past(line_state) & ~line_state)) |->
            ($past(poll_tick) && (($past(line_state) & ~line_state & ~$past(chk_pass)) == '0)));

    // R7: abnormal right after reset
    a_r7_reset_abnormal: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(rst_n) |-> (line_state == '1));

    // R9: working bit repeated one cycle later
    a_r9_working_pass: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) |-> (status[4*N_SRC] == $past(src_working)));

    for (genvar s = 0; s < N_SRC; s++) begin : g_chk
        // R8: status line field follows line state by one cycle
        a_r8_status_line: assert property (@(posedge clk_ref) disable iff (!rst_n)
            $past(rst_n) |-> (status[4*s+2] == $past(line_state[s])));
    end
endmodule

bind clkfp_health_mon clkfp_health_mon_sva #(.N_SRC(N_SRC)) u_sva (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .poll_tick  (poll_tick),
    .chk_pass   (chk_pass),
    .line_state (line_state),
    .status     (status),
    .src_working(src_working)
);

// File: tb/tb_clkfp_health_mon.sv
`timescale 1ns/1ps
module tb_clkfp_health_mon;
    localparam int N = 2;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] mon_clk = 2'b00;
    logic [1:0] frame_pulse = 2'b00;
    logic [1:0] src_absent  = 2'b00;
    logic [1:0] src_fault   = 2'b00;
    logic       src_working = 1'b0;
    logic [1:0] line_state;
    logic [8:0] status;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    real half_a = 10.0;
    real half_b = 10.0;

    clkfp_health_mon #(
        .N_SRC(N), .POLL_CYCLES(1000), .GATE_CYCLES(200),
        .CLK_NOM_EDGES(50), .CLK_TOL(2), .FP_PERIOD(100), .FP_TOL(1),
        .GOOD_NEEDED(5)
    ) dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .mon_clk(mon_clk),
        .frame_pulse(frame_pulse), .src_absent(src_absent),
        .src_fault(src_fault), .src_working(src_working),
        .line_state(line_state), .status(status)
    );

    always #2.5 clk_ref = ~clk_ref;
    always begin #(half_a); mon_clk[0] = ~mon_clk[0]; end
    always begin #(half_b); mon_clk[1] = ~mon_clk[1]; end

    always @(posedge clk_ref) if (rst_n) cyc <= cyc + 1;

    function automatic bit base_hit(int c);
        return (c >= 20) && (((c - 20) % 100) == 0);
    endfunction

    // stimulus schedule: A skips 5520, extra at 12550, slow clock 16500..17500
    // B shifts 7520 by +1 and 8520 by +2
    always @(negedge clk_ref) begin
        frame_pulse[0] <= rst_n && ((base_hit(cyc) && cyc != 5520) || cyc == 12550);
        frame_pulse[1] <= rst_n && ((base_hit(cyc) && cyc != 7520 && cyc != 8520)
                                    || cyc == 7521 || cyc == 8522);
        half_a = (cyc >= 16500 && cyc < 17500) ? 12.5 : 10.0;
    end

    task automatic wait_cyc(int t);
        while (cyc < t) @(negedge clk_ref);
    endtask

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic t_reset;
        wait_cyc(500);
        check("R7 line after reset", {7'd0, line_state}, 9'h003);
        check("R8 status after reset", status, 9'h0CC);
    endtask

    task automatic t_first_recovery;
        wait_cyc(4500);
        check("R4 still abnormal after four passes", {7'd0, line_state}, 9'h003);
        wait_cyc(4999);
        check("R1 no change before boundary", {7'd0, line_state}, 9'h003);
        wait_cyc(5000);
        check("R1 change on boundary edge", {7'd0, line_state}, 9'h000);
        wait_cyc(5500);
        check("R8 status all normal", status, 9'h000);
    endtask

    task automatic t_missing_pulse;
        wait_cyc(6500);
        check("R5 R3 missing pulse on A, R6 B unaffected", {7'd0, line_state}, 9'h001);
    endtask

    task automatic t_spacing_tolerance;
        wait_cyc(8500);
        check("R5 gap off by one passes on B", {7'd0, line_state}, 9'h001);
        wait_cyc(9500);
        check("R5 gap off by two fails on B", {7'd0, line_state}, 9'h003);
    endtask

    task automatic t_status_fields;
        wait_cyc(9600);
        src_working = 1'b1; src_absent = 2'b01; src_fault = 2'b10;
        wait_cyc(9700);
        check("R8 R9 status fields", status, 9'h1ED);
        wait_cyc(9800);
        src_working = 1'b0; src_absent = 2'b00; src_fault = 2'b00;
        wait_cyc(9850);
        check("R9 working bit cleared", status, 9'h0CC);
    endtask

    task automatic t_recover_a;
        wait_cyc(10500);
        check("R4 A needs fifth pass", {7'd0, line_state}, 9'h003);
        wait_cyc(11500);
        check("R4 A normal, R6 B still abnormal", {7'd0, line_state}, 9'h002);
    endtask

    task automatic t_extra_pulse;
        wait_cyc(13500);
        check("R5 extra pulse on A", {7'd0, line_state}, 9'h003);
        wait_cyc(14500);
        check("R4 B recovered, R6 A independent", {7'd0, line_state}, 9'h001);
    endtask

    task automatic t_slow_clock;
        wait_cyc(18500);
        check("R2 R3 slow clock fails A", {7'd0, line_state}, 9'h001);
        wait_cyc(22500);
        check("R4 bad check restarted count", {7'd0, line_state}, 9'h001);
        wait_cyc(23500);
        check("R4 A normal after five fresh passes", {7'd0, line_state}, 9'h000);
        check("R8 final status", status, 9'h000);
    endtask

    initial begin
        repeat (4) @(negedge clk_ref);
        check("R8 status in reset", status, 9'h000);
        rst_n = 1'b1;
        t_reset();
        t_first_recovery();
        t_missing_pulse();
        t_spacing_tolerance();
        t_status_fields();
        t_recover_a();
        t_extra_pulse();
        t_slow_clock();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule